// File: doc/BRIEF.md
# Condition-Code ALU

This block is the arithmetic and logic stage of a small integer datapath. Each cycle it may accept two operands, an operand size, an operation code, a branch-condition selector and the current condition-code byte. One clock later it presents the result, a flag saying whether that result should be written back, the updated condition-code byte, and whether the selected branch condition holds for the flags that came in.

The datapath is built as one lane per operand width (8, 16 and 32 bits), each lane computing every operation at its own width. The operand size picks one lane. Three operations bypass the lanes and combine an immediate byte with the condition-code byte itself. The branch evaluator reads the incoming flags only. It shares nothing with the lanes, so a sequencer can test a condition on the same cycle that it issues an operation.

Top module: `alu_ccr_unit`

## Requirements
- R1: The condition-code byte holds C at bit 0, V at bit 1, Z at bit 2 and N at bit 3. For every opcode below 11, bits 7:4 of `ccr_out` equal bits 7:4 of `ccr_in`.
- R2: `size` 0 selects 8-bit, 1 selects 16-bit, and 2 or 3 select 32-bit operands. Operand bits above the selected width have no effect, and the result is zero-extended to 32 bits.
- R3: Opcode 0 (add) yields a+b. C is the carry out of the top bit of the selected width. V is set when both operands have the same sign and the result's sign differs from it.
- R4: Opcode 1 (subtract) yields a-b. C is set when b is larger than a as unsigned numbers. V is set when the operand signs differ and the result's sign differs from a's sign.
- R5: Opcode 2 (compare) sets the flags exactly as subtract does, but `store_en` is 0.
- R6: Opcode 3 (negate) yields 0-a. V is set only when a is the most negative value of the width. C is set when a is nonzero.
- R7: Opcodes 4 and 5 add 1 and 2, and opcodes 6 and 7 subtract 1 and 2. C keeps its incoming value. V is set when an increment turns a non-negative value negative, or when a decrement turns a negative value non-negative.
- R8: Opcodes 8, 9 and 10 yield a AND b, a OR b and a XOR b. V is cleared and C keeps its incoming value.
- R9: Opcodes 11, 12 and 13 set the whole `ccr_out` byte to `ccr_in` AND, OR or XOR `op_b[7:0]`. `store_en` is 0 and `result` is the new byte zero-extended.
- R10: For opcodes 0 to 10, N is the top bit of the result at the selected width, and Z is set when that result is zero.
- R11: `cond_true` reflects `ccr_in` for the selector `cond`: 0 always, 1 never, 2 C|Z clear, 3 C|Z set, 4 C clear, 5 C set, 6 Z clear, 7 Z set, 8 V clear, 9 V set, 10 N clear, 11 N set, 12 N==V, 13 N!=V, 14 (Z or (N xor V)) is 0, and 15 as the complement of 14.
- R12: Outputs are registered with one cycle of latency. `out_valid` follows `in_valid` one cycle later. Without `in_valid`, `result`, `store_en`, `ccr_out` and `cond_true` hold their values.
- R13: Reset drives all outputs to 0. Opcodes 14 and 15 give a result of 0, `store_en` 0, and `ccr_out` equal to `ccr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept this cycle's operation |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, or immediate byte for the condition-code operations |
| size | input | 2 | Operand width selector |
| opcode | input | 4 | Operation code |
| cond | input | 4 | Branch-condition selector |
| ccr_in | input | 8 | Current condition-code byte |
| out_valid | output | 1 | Registered outputs were updated last cycle |
| result | output | 32 | Zero-extended result |
| store_en | output | 1 | Result should be written back |
| ccr_out | output | 8 | New condition-code byte |
| cond_true | output | 1 | Selected branch condition holds |

## Verification
Assertions check several properties on every cycle:

- Compare and the condition-code operations never request a store.
- Increment, decrement and the logical operations keep C.
- Logical operations clear V.
- The upper nibble of the condition-code byte passes through unchanged.
- Z agrees with a stored result.
- Byte results are zero-extended.
- Idle cycles hold the outputs.

Only the bench's scenarios can show the arithmetic values themselves. This covers carry and borrow at each width boundary, the two overflow rules, the most-negative negate, the inc/dec crossings, and the sixteen branch conditions, all compared against independently computed expectations.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_CMP   = 4'd2,
      OP_NEG   = 4'd3,
      OP_INC1  = 4'd4,
      OP_INC2  = 4'd5,
      OP_DEC1  = 4'd6,
      OP_DEC2  = 4'd7,
      OP_AND   = 4'd8,
      OP_OR    = 4'd9,
      OP_XOR   = 4'd10,
      OP_CCAND = 4'd11,
      OP_CCOR  = 4'd12,
      OP_CCXOR = 4'd13,
      OP_RSV14 = 4'd14,
      OP_RSV15 = 4'd15
   } alu_op_e;

   // Packed so that {n,z,v,c} lands on bits 3..0 of the condition byte
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

   localparam int CCR_W     = 8;
   localparam int FLAG_W    = 4;
   localparam int CC_BIT_C  = 0;
   localparam int CC_BIT_V  = 1;
   localparam int CC_BIT_Z  = 2;
   localparam int CC_BIT_N  = 3;

   function automatic logic is_ccr_op(alu_op_e op);
      return (op == OP_CCAND) || (op == OP_CCOR) || (op == OP_CCXOR);
   endfunction

   function automatic logic is_reserved(alu_op_e op);
      return (op == OP_RSV14) || (op == OP_RSV15);
   endfunction

   function automatic flags_t unpack_flags(logic [CCR_W-1:0] cc);
      flags_t f;
      f.c = cc[CC_BIT_C];
      f.v = cc[CC_BIT_V];
      f.z = cc[CC_BIT_Z];
      f.n = cc[CC_BIT_N];
      return f;
   endfunction

endpackage

// File: rtl/alu_lane.sv
module alu_lane
   import alu_ccr_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           carry_in,
   output logic [W-1:0]   res,
   output flags_t         flg
);

   localparam int MSB = W - 1;
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   initial begin
      if (W < 2) $error("alu_lane: width must be at least 2");
   end

   logic [W:0]   sum_ext;
   logic [W:0]   dif_ext;
   logic [W-1:0] step;
   logic [W-1:0] bumped_up;
   logic [W-1:0] bumped_dn;

   always_comb begin
      sum_ext   = {1'b0, a} + {1'b0, b};
      dif_ext   = {1'b0, a} - {1'b0, b};
      step      = ((op == OP_INC2) || (op == OP_DEC2)) ? W'(2) : W'(1);
      bumped_up = a + step;
      bumped_dn = a - step;
   end

   always_comb begin
      res   = '0;
      flg.v = 1'b0;
      flg.c = carry_in;
      unique case (op)
         OP_ADD: begin
            res   = sum_ext[W-1:0];
            flg.c = sum_ext[W];
            flg.v = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
         end
         OP_SUB, OP_CMP: begin
            res   = dif_ext[W-1:0];
            flg.c = dif_ext[W];
            flg.v = (a[MSB] != b[MSB]) && (dif_ext[MSB] != a[MSB]);
         end
         OP_NEG: begin
            res   = W'(0) - a;
            flg.c = |a;
            flg.v = (a == MOST_NEG);
         end
         OP_INC1, OP_INC2: begin
            res   = bumped_up;
            flg.v = !a[MSB] && bumped_up[MSB];
         end
         OP_DEC1, OP_DEC2: begin
            res   = bumped_dn;
            flg.v = a[MSB] && !bumped_dn[MSB];
         end
         OP_AND: res = a & b;
         OP_OR:  res = a | b;
         OP_XOR: res = a ^ b;
         default: res = '0;
      endcase
      flg.n = res[MSB];
      flg.z = (res == '0);
   end

endmodule

// File: rtl/alu_ccr_imm.sv
module alu_ccr_imm
   import alu_ccr_pkg::*;
(
   input  alu_op_e           op,
   input  logic [CCR_W-1:0]  cc_cur,
   input  logic [CCR_W-1:0]  imm,
   output logic [CCR_W-1:0]  cc_new
);

   always_comb begin
      unique case (op)
         OP_CCAND: cc_new = cc_cur & imm;
         OP_CCOR:  cc_new = cc_cur | imm;
         OP_CCXOR: cc_new = cc_cur ^ imm;
         default:  cc_new = cc_cur;
      endcase
   end

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
   import alu_ccr_pkg::*;
(
   input  logic [3:0] sel,
   input  flags_t     f,
   output logic       holds
);

   logic base;
   logic n_ne_v;

   always_comb begin
      n_ne_v = f.n ^ f.v;
      // Even selectors test a predicate, odd ones its complement
      unique case (sel[3:1])
         3'd0: base = 1'b1;
         3'd1: base = !(f.c || f.z);
         3'd2: base = !f.c;
         3'd3: base = !f.z;
         3'd4: base = !f.v;
         3'd5: base = !f.n;
         3'd6: base = !n_ne_v;
         default: base = !(f.z || n_ne_v);
      endcase
      holds = sel[0] ? !base : base;
   end

endmodule

// File: rtl/alu_ccr_unit.sv
module alu_ccr_unit
   import alu_ccr_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_SIZES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [1:0]        size,
   input  logic [3:0]        opcode,
   input  logic [3:0]        cond,
   input  logic [7:0]        ccr_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              store_en,
   output logic [7:0]        ccr_out,
   output logic              cond_true
);

   localparam int BASE_W   = 8;
   localparam int LAST_IDX = NUM_SIZES - 1;

   initial begin
      if (NUM_SIZES < 1 || NUM_SIZES > 4)
         $error("alu_ccr_unit: NUM_SIZES must be 1..4");
      if (DATA_W != (BASE_W << LAST_IDX))
         $error("alu_ccr_unit: DATA_W must equal the widest lane");
   end

   alu_op_e op_e;
   flags_t  cur_flags;
   assign op_e      = alu_op_e'(opcode);
   assign cur_flags = unpack_flags(ccr_in);

   logic [DATA_W-1:0] lane_res [NUM_SIZES];
   flags_t            lane_flg [NUM_SIZES];

   // One lane per operand width; widths double from BASE_W
   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
      localparam int LW = BASE_W << k;
      logic [LW-1:0] res_w;
      alu_lane #(.W(LW)) u_lane (
         .op       (op_e),
         .a        (op_a[LW-1:0]),
         .b        (op_b[LW-1:0]),
         .carry_in (cur_flags.c),
         .res      (res_w),
         .flg      (lane_flg[k])
      );
      if (LW == DATA_W) begin : g_full
         assign lane_res[k] = res_w;
      end else begin : g_ext
         assign lane_res[k] = {{(DATA_W-LW){1'b0}}, res_w};
      end
   end

   logic [1:0] lane_idx;
   always_comb begin
      if (int'(size) > LAST_IDX) lane_idx = 2'(LAST_IDX);
      else                       lane_idx = size;
   end

   logic [7:0] cc_imm_new;
   alu_ccr_imm u_ccimm (
      .op     (op_e),
      .cc_cur (ccr_in),
      .imm    (op_b[7:0]),
      .cc_new (cc_imm_new)
   );

   logic cond_now;
   alu_cond_eval u_cond (
      .sel   (cond),
      .f     (cur_flags),
      .holds (cond_now)
   );

   logic [DATA_W-1:0] nxt_res;
   logic              nxt_store;
   logic [7:0]        nxt_ccr;

   always_comb begin
      if (is_ccr_op(op_e)) begin
         nxt_res   = {{(DATA_W-8){1'b0}}, cc_imm_new};
         nxt_store = 1'b0;
         nxt_ccr   = cc_imm_new;
      end else if (is_reserved(op_e)) begin
         nxt_res   = '0;
         nxt_store = 1'b0;
         nxt_ccr   = ccr_in;
      end else begin
         nxt_res   = lane_res[lane_idx];
         nxt_store = (op_e != OP_CMP);
         nxt_ccr   = {ccr_in[7:FLAG_W], lane_flg[lane_idx]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         store_en  <= 1'b0;
         ccr_out   <= '0;
         cond_true <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= nxt_res;
            store_en  <= nxt_store;
            ccr_out   <= nxt_ccr;
            cond_true <= cond_now;
         end
      end
   end

   // Assertions
   assert_upper_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode < 4'd11) |=> (ccr_out[7:4] == $past(ccr_in[7:4])));

   assert_byte_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size == 2'd0 && opcode < 4'd11) |=> (result[DATA_W-1:8] == '0));

   assert_cmp_no_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 4'd2) |=> !store_en);

   assert_step_keeps_c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode >= 4'd4 && opcode <= 4'd7) |=> (ccr_out[0] == $past(ccr_in[0])));

   assert_logic_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode >= 4'd8 && opcode <= 4'd10)
      |=> (!ccr_out[1] && ccr_out[0] == $past(ccr_in[0])));

   assert_imm_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode >= 4'd11 && opcode <= 4'd13)
      |=> (!store_en && result[DATA_W-1:8] == '0));

   assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && store_en) |-> (ccr_out[2] == (result == '0)));

   assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(ccr_out) && $stable(store_en)));

   assert_reserved_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode >= 4'd14) |=> (!store_en && result == '0 && ccr_out == $past(ccr_in)));

endmodule

// File: tb/alu_ccr_unit_test.sv
`timescale 1ns/1ps
module alu_ccr_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [1:0]  size = '0;
   logic [3:0]  opcode = '0, cond = '0;
   logic [7:0]  ccr_in = '0;
   logic        out_valid, store_en, cond_true;
   logic [31:0] result;
   logic [7:0]  ccr_out;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   alu_ccr_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .size(size), .opcode(opcode), .cond(cond), .ccr_in(ccr_in),
      .out_valid(out_valid), .result(result), .store_en(store_en),
      .ccr_out(ccr_out), .cond_true(cond_true)
   );

   function automatic string req_of(int op);
      case (op)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4, 5, 6, 7: return "R7";
         8, 9, 10: return "R8";
         11, 12, 13: return "R9";
         default: return "R13";
      endcase
   endfunction

   function automatic logic cond_model(int c, logic [7:0] cc);
      logic fc = cc[0], fv = cc[1], fz = cc[2], fn = cc[3];
      case (c)
         0: return 1'b1;
         1: return 1'b0;
         2: return !(fc | fz);
         3: return fc | fz;
         4: return !fc;
         5: return fc;
         6: return !fz;
         7: return fz;
         8: return !fv;
         9: return fv;
         10: return !fn;
         11: return fn;
         12: return fn == fv;
         13: return fn != fv;
         14: return (fz | (fn ^ fv)) == 1'b0;
         default: return (fz | (fn ^ fv)) == 1'b1;
      endcase
   endfunction

   task automatic model(input int op, input int sz, input logic [31:0] a, b,
                        input logic [7:0] cc, output logic [31:0] r,
                        output logic st, output logic [7:0] cco);
      int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
      longint unsigned m = (64'd1 << w) - 1;
      longint unsigned top = 64'd1 << (w - 1);
      longint unsigned sa = a & m, sb = b & m, x = 0;
      logic n, z, v, c;
      c = cc[0]; v = cc[1];
      if (op >= 11) begin
         st = 1'b0;
         if (op == 11) cco = cc & b[7:0];
         else if (op == 12) cco = cc | b[7:0];
         else if (op == 13) cco = cc ^ b[7:0];
         else cco = cc;
         r = (op <= 13) ? {24'd0, cco} : 32'd0;
         return;
      end
      case (op)
         0: begin x = sa + sb; c = x > m; x = x & m;
                  v = ((sa & top) == (sb & top)) && ((x & top) != (sa & top)); end
         1, 2: begin x = (sa - sb) & m; c = sa < sb;
                  v = ((sa & top) != (sb & top)) && ((x & top) != (sa & top)); end
         3: begin x = (0 - sa) & m; c = sa != 0; v = sa == top; end
         4, 5: begin x = (sa + longint'(op - 3)) & m; v = (sa < top) && (x >= top); end
         6, 7: begin x = (sa - longint'(op - 5)) & m; v = (sa >= top) && (x < top); end
         8: begin x = sa & sb; v = 0; end
         9: begin x = sa | sb; v = 0; end
         default: begin x = sa ^ sb; v = 0; end
      endcase
      n = (x & top) != 0;
      z = x == 0;
      r = x[31:0];
      st = (op != 2);
      cco = {cc[7:4], n, z, v, c};
   endtask

   task automatic run_op(input int op, input int sz, input logic [31:0] a, b,
                         input logic [7:0] cc, input int c);
      logic [31:0] er; logic es; logic [7:0] ec; logic ect;
      @(negedge clk);
      in_valid = 1; opcode = 4'(op); size = 2'(sz); op_a = a; op_b = b;
      ccr_in = cc; cond = 4'(c);
      model(op, sz, a, b, cc, er, es, ec);
      ect = cond_model(c, cc);
      @(negedge clk);
      in_valid = 0;
      checks++;
      if (result !== er || store_en !== es || ccr_out !== ec || out_valid !== 1'b1) begin
         errors++;
         $display("FAIL %s (R2 R10 R12): op=%0d sz=%0d a=%h b=%h ccr=%h got res=%h st=%b cc=%h ov=%b exp res=%h st=%b cc=%h ov=1",
                  req_of(op), op, sz, a, b, cc, result, store_en, ccr_out, out_valid, er, es, ec);
      end
      checks++;
      if (cond_true !== ect) begin
         errors++;
         $display("FAIL R11: cond=%0d ccr=%h got %b expected %b", c, cc, cond_true, ect);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] hr; logic [7:0] hc; logic hs, ht;
      void'($urandom(32'h1D5E));
      repeat (3) @(negedge clk);
      // R13 reset state
      checks++;
      if (out_valid !== 0 || result !== 0 || store_en !== 0 || ccr_out !== 0 || cond_true !== 0) begin
         errors++;
         $display("FAIL R13: reset outputs got %b %h %b %h %b expected all zero",
                  out_valid, result, store_en, ccr_out, cond_true);
      end
      rst_n = 1;
      // R3 carries and overflow at each width
      run_op(0, 0, 32'h7F, 32'h01, 8'hF0, 14);
      run_op(0, 0, 32'hFF, 32'h01, 8'h00, 7);
      run_op(0, 1, 32'hFFFF, 32'h0001, 8'h00, 5);
      run_op(0, 2, 32'hFFFFFFFF, 32'h1, 8'h00, 3);
      run_op(0, 3, 32'h80000000, 32'h80000000, 8'hA0, 9);
      // R2 upper bits ignored
      run_op(0, 0, 32'hABCD_1203, 32'h5555_FF04, 8'h00, 0);
      // R4 borrow and overflow
      run_op(1, 0, 32'h80, 32'h01, 8'h00, 13);
      run_op(1, 0, 32'h7F, 32'hFF, 8'h00, 13);
      run_op(1, 1, 32'h0001, 32'h0002, 8'h00, 2);
      // R5 compare
      run_op(2, 2, 32'h5, 32'h5, 8'h0F, 6);
      // R6 negate
      run_op(3, 0, 32'h80, 32'h0, 8'h00, 9);
      run_op(3, 1, 32'h0, 32'h0, 8'h0F, 4);
      run_op(3, 2, 32'h80000000, 32'h0, 8'h00, 11);
      // R7 inc/dec crossings and kept carry
      run_op(4, 0, 32'h7F, 32'h0, 8'h01, 9);
      run_op(5, 1, 32'h7FFE, 32'h0, 8'h00, 8);
      run_op(6, 0, 32'h80, 32'h0, 8'h01, 5);
      run_op(7, 2, 32'h80000001, 32'h0, 8'h00, 12);
      run_op(6, 2, 32'h0, 32'h0, 8'h01, 15);
      // R8 logic
      run_op(8, 0, 32'hF0, 32'h0F, 8'h03, 7);
      run_op(10, 1, 32'h8001, 32'h0001, 8'h02, 11);
      // R9 condition-code immediates, R1 layout
      run_op(11, 0, 32'h0, 32'h0000_00F4, 8'hFF, 0);
      run_op(12, 2, 32'h0, 32'h0000_000A, 8'h50, 1);
      run_op(13, 1, 32'h0, 32'h0000_00FF, 8'h3C, 10);
      // R13 reserved
      run_op(14, 0, 32'h12, 32'h34, 8'h9A, 0);
      run_op(15, 2, 32'h12, 32'h34, 8'h65, 1);
      // R11 all selectors over all flag patterns
      for (int c = 0; c < 16; c++)
         for (int f = 0; f < 16; f++)
            run_op(14, 0, 32'h0, 32'h0, 8'(f), c);
      // R12 hold with idle input
      @(negedge clk);
      hr = result; hc = ccr_out; hs = store_en; ht = cond_true;
      opcode = 4'd0; op_a = 32'h1234; op_b = 32'h4321; ccr_in = 8'hFF; cond = 4'd1;
      @(negedge clk);
      checks++;
      if (out_valid !== 0 || result !== hr || ccr_out !== hc || store_en !== hs || cond_true !== ht) begin
         errors++;
         $display("FAIL R12: idle got ov=%b res=%h cc=%h expected ov=0 res=%h cc=%h",
                  out_valid, result, ccr_out, hr, hc);
      end
      // Constrained random mix
      for (int i = 0; i < 3000; i++) begin
         int op = $urandom_range(0, 15);
         int sz = $urandom_range(0, 3);
         int c = $urandom_range(0, 15);
         logic [31:0] a = $urandom;
         logic [31:0] b = $urandom;
         if ($urandom_range(0, 3) == 0) a = (i % 2 == 0) ? 32'h0 : 32'hFFFFFFFF;
         run_op(op, sz, a, b, 8'($urandom), c);
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule